// File: doc/BRIEF.md
# Single-Endpoint Packet Buffer with Processor Data Port

This block holds one USB endpoint's packet between a local processor and the serial interface engine (SIE), and works in either direction. When `dir_in` is high the endpoint is IN. The processor writes bytes through a 16-bit data port, either 8 or 16 bits at a time. The buffer commits the packet by itself once the number of bytes written reaches the programmed packet length. The processor can also commit it early with a force-validate strobe. The next IN token then streams the packet out one byte per cycle. After that the buffer is empty and can be filled again.

When `dir_in` is low the endpoint is OUT. An OUT token that finds the buffer empty opens reception: the SIE pushes bytes, then marks the end of the packet. The processor drains the packet through the same data port. The buffer empties itself when the last byte has been read. A force-clear strobe discards the contents at any time, in either direction. Tokens that cannot be served are refused: an IN token before the packet is committed, or an OUT token while a packet is still unread. The block answers each one with a one-cycle NAK pulse.

The packet length register is loaded with the maximum packet size whenever that size is written. Software may then write a smaller length, which makes a short packet commit at that count. A USB bus reset clears the length to zero and empties the buffer. `dir_in` is expected to change only while the buffer is empty.

Top module: `epb_endpoint_buffer`

## Requirements
- R1: A maximum-packet-size write (`mps_wr`) loads `pkt_len` with `mps_data`, clamped to DEPTH. A length write (`len_wr`) loads `pkt_len` with `len_data`, clamped the same way. When both strobes come in the same cycle, `mps_wr` wins. The new value shows on `pkt_len` one cycle after the strobe.
- R2: `rst_n` low or `bus_reset` high clears `pkt_len` to 0, empties the buffer (`buf_ready`=0, `buf_count`=0) and clears both NAK outputs.
- R3: In IN mode, an 8-bit port write stores `port_wdata[7:0]` as the next byte. A 16-bit write (`port_wide`=1) stores `[7:0]` first and then `[15:8]`. The number of bytes stored is limited to `pkt_len`, or to DEPTH when `pkt_len` is 0. A write that brings `buf_count` to `pkt_len` or beyond sets `buf_ready`. This happens only when `pkt_len` is nonzero.
- R4: In IN mode, `force_valid` sets `buf_ready` with the current `buf_count`, which may be zero.
- R5: In IN mode, an `in_token` while `buf_ready` is 0 produces a one-cycle `in_nak` in the following cycle, and no transmission.
- R6: In IN mode, an `in_token` while `buf_ready` is 1 streams the stored bytes in write order. Each byte is one cycle with `tx_valid`=1, and the first comes in the cycle after the token. A one-cycle `tx_end` follows the last byte. One cycle after that, `buf_ready` and `buf_count` are 0 and writes are accepted again. Port writes made while `buf_ready` is 1 are ignored.
- R7: In OUT mode, an `out_token` on an empty buffer starts reception. Each `rx_valid` cycle stores `rx_data`. `rx_end` with at least one byte stored sets `buf_ready`, with `buf_count` equal to the number of bytes. A packet with no bytes leaves the buffer empty.
- R8: In OUT mode, an `out_token` while an unread packet is held produces a one-cycle `out_nak` in the following cycle and leaves the contents unchanged.
- R9: While an OUT packet is held, `port_rdata` shows the next unread byte in `[7:0]`. With `port_wide`=1 it also shows the byte after it in `[15:8]`; with `port_wide`=0, `[15:8]` is 0. `port_rd` consumes 2 bytes when `port_wide` is 1 and 1 byte when it is 0.
- R10: A 16-bit read when one byte remains shows that byte in `[7:0]` and 0 in `[15:8]`, and it empties the buffer.
- R11: Once the last byte is consumed, `buf_ready` and `buf_count` drop to 0 on the next cycle. `port_rdata` reads 0 whenever no OUT packet is held, and a new `out_token` is accepted.
- R12: `force_clear` empties the buffer in either direction by the next cycle, and it takes priority over any token or data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset, acts like reset |
| dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| mps_wr | input | 1 | Write strobe for the maximum packet size |
| mps_data | input | MPS_W | Maximum packet size value |
| len_wr | input | 1 | Write strobe for the packet length |
| len_data | input | MPS_W | Packet length value |
| force_valid | input | 1 | Commit the IN packet now |
| force_clear | input | 1 | Discard the buffer contents |
| port_wr | input | 1 | Data port write strobe |
| port_rd | input | 1 | Data port read strobe |
| port_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| port_wdata | input | 16 | Data port write value |
| port_rdata | output | 16 | Data port read value |
| in_token | input | 1 | IN token pulse from the SIE |
| in_nak | output | 1 | IN token refused |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_end | output | 1 | Transmit packet finished |
| out_token | input | 1 | OUT token pulse from the SIE |
| out_nak | output | 1 | OUT token refused |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Received packet finished |
| buf_ready | output | 1 | IN packet committed, or OUT packet held |
| buf_count | output | CNT_W | IN: bytes stored; OUT: bytes not yet read |
| pkt_len | output | CNT_W | Packet length register |

## Verification
A wrong byte count or pointer shows up at the ports as soon as the next cycle. It appears as an early or late `buf_ready`, a shifted `buf_count`, or a byte on `port_rdata` or `tx_data` that differs from the one expected in that cycle. A state machine stuck in the wrong phase shows up as a missing or extra NAK one cycle after the token, or as a `tx_end` that arrives off by a cycle. Because all of these outputs are compared every cycle, a corrupted pointer or count is caught in the first cycle it reaches a port. The same holds for a misordered byte, or for a clear that arrives late.

// File: rtl/epb_pkg.sv
// Package epb_pkg
// Holds the types shared by the endpoint buffer modules.
// Assumes: the data port is two bytes wide.
package epb_pkg;
    localparam int BYTE_W = 8;
    localparam int PORT_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // IN: filling; OUT: empty
        ST_SEND = 2'd1,   // IN: streaming a packet to the SIE
        ST_RECV = 2'd2,   // OUT: receiving a packet from the SIE
        ST_HOLD = 2'd3    // OUT: packet held for the processor
    } epb_state_t;
endpackage

// File: rtl/epb_len_reg.sv
// Module epb_len_reg
// Keeps the packet length register. Writing the maximum packet size also
// loads the length, and a later length write may override it. Both values
// are clamped to the buffer depth.
// Assumes: MPS_W is at least as wide as the count width.
module epb_len_reg #(
    parameter int DEPTH = 64,
    parameter int MPS_W = 11,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             mps_wr,
    input  logic [MPS_W-1:0] mps_data,
    input  logic             len_wr,
    input  logic [MPS_W-1:0] len_data,
    output logic [CNT_W-1:0] len_q
);
    // Limit a requested size to what the buffer can hold.
    function automatic logic [CNT_W-1:0] clamp_len(input logic [MPS_W-1:0] v);
        if (32'(v) > DEPTH) return CNT_W'(DEPTH);
        return v[CNT_W-1:0];
    endfunction

    // Length register update; a size write beats a length write.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            len_q <= '0;
        end else if (mps_wr) begin
            len_q <= clamp_len(mps_data);
        end else if (len_wr) begin
            len_q <= clamp_len(len_data);
        end
    end
endmodule

// File: rtl/epb_byte_ram.sv
// Module epb_byte_ram
// Byte storage with two write ports and two asynchronous read ports, so a
// 16-bit access can move two bytes in one cycle.
// Assumes: the two write addresses differ whenever both enables are high.
module epb_byte_ram #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we0,
    input  logic [ADDR_W-1:0] wa0,
    input  logic [7:0]        wd0,
    input  logic              we1,
    input  logic [ADDR_W-1:0] wa1,
    input  logic [7:0]        wd1,
    input  logic [ADDR_W-1:0] ra0,
    output logic [7:0]        rd0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [7:0]        rd1
);
    logic [7:0] mem [DEPTH];

    // Store up to two bytes per cycle.
    always_ff @(posedge clk) begin
        if (we0) mem[wa0] <= wd0;
        if (we1) mem[wa1] <= wd1;
    end

    // Read the two addressed bytes.
    always_comb begin
        rd0 = mem[ra0];
        rd1 = mem[ra1];
    end
endmodule

// File: rtl/epb_seq.sv
// Module epb_seq
// Sequencer for the endpoint buffer. It keeps the byte count, the read or
// transmit pointer, the committed flag and the phase. It decides which
// bytes are written and read, and when the buffer validates or frees itself.
// Assumes: dir_in changes only while the buffer is empty.
module epb_seq
    import epb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              dir_in,
    input  logic [CNT_W-1:0]  len_q,
    input  logic              force_valid,
    input  logic              force_clear,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic              port_wide,
    input  logic              in_token,
    input  logic              out_token,
    input  logic              rx_valid,
    input  logic              rx_end,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              rx_wr,
    output logic [ADDR_W-1:0] wa0,
    output logic [ADDR_W-1:0] wa1,
    output logic [ADDR_W-1:0] ra0,
    output logic [ADDR_W-1:0] ra1,
    output logic              hold,
    output logic              hi_ok,
    output logic              tx_valid,
    output logic              tx_end,
    output logic              in_nak,
    output logic              out_nak,
    output logic              buf_ready,
    output logic [CNT_W-1:0]  buf_count
);
    epb_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ptr_q;
    logic             valid_q;
    logic             in_nak_q;
    logic             out_nak_q;

    logic             fill_ok;
    logic [CNT_W-1:0] cap;
    logic [CNT_W:0]   add_cnt;
    logic [CNT_W:0]   adv;
    logic [CNT_W:0]   ptr_nx;
    logic             auto_commit;

    // Fill control: which port bytes land and what the count becomes.
    always_comb begin
        fill_ok     = dir_in && (st_q == ST_IDLE) && !valid_q;
        cap         = (len_q != '0) ? len_q : CNT_W'(DEPTH);
        wr_lo       = fill_ok && port_wr && (cnt_q < cap);
        wr_hi       = fill_ok && port_wr && port_wide
                      && (({1'b0, cnt_q} + 1'b1) < {1'b0, cap});
        rx_wr       = !dir_in && (st_q == ST_RECV) && rx_valid
                      && (cnt_q < CNT_W'(DEPTH));
        add_cnt     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, wr_lo}
                      + {{CNT_W{1'b0}}, wr_hi};
        auto_commit = port_wr && (len_q != '0) && (add_cnt >= {1'b0, len_q});
        adv         = {1'b0, ptr_q} + (port_wide ? 2 : 1);
        ptr_nx      = {1'b0, ptr_q} + 1'b1;
    end

    // Addresses for writes (at the count) and reads (at the pointer).
    always_comb begin
        wa0 = ADDR_W'(cnt_q);
        wa1 = ADDR_W'(cnt_q + 1'b1);
        ra0 = ADDR_W'(ptr_q);
        ra1 = ADDR_W'(ptr_q + 1'b1);
    end

    // Phase-derived outputs seen by the SIE and the processor.
    always_comb begin
        hold      = !dir_in && (st_q == ST_HOLD);
        hi_ok     = hold && port_wide && (ptr_nx < {1'b0, cnt_q});
        tx_valid  = dir_in && (st_q == ST_SEND) && (ptr_q < cnt_q);
        tx_end    = dir_in && (st_q == ST_SEND) && (ptr_q == cnt_q);
        buf_ready = dir_in ? valid_q : hold;
        buf_count = dir_in ? cnt_q : (cnt_q - ptr_q);
        in_nak    = in_nak_q;
        out_nak   = out_nak_q;
    end

    // Phase, count, pointer and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            ptr_q     <= '0;
            valid_q   <= 1'b0;
            in_nak_q  <= 1'b0;
            out_nak_q <= 1'b0;
        end else begin
            in_nak_q  <= 1'b0;
            out_nak_q <= 1'b0;
            if (force_clear) begin
                st_q    <= ST_IDLE;
                cnt_q   <= '0;
                ptr_q   <= '0;
                valid_q <= 1'b0;
            end else if (dir_in) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (in_token) begin
                            if (valid_q) begin
                                st_q  <= ST_SEND;
                                ptr_q <= '0;
                            end else begin
                                in_nak_q <= 1'b1;
                            end
                        end
                        if (fill_ok) begin
                            cnt_q <= add_cnt[CNT_W-1:0];
                            if (force_valid || auto_commit) valid_q <= 1'b1;
                        end
                    end
                    ST_SEND: begin
                        if (ptr_q < cnt_q) begin
                            ptr_q <= ptr_q + 1'b1;
                        end else begin
                            st_q    <= ST_IDLE;
                            cnt_q   <= '0;
                            ptr_q   <= '0;
                            valid_q <= 1'b0;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (out_token) begin
                            st_q  <= ST_RECV;
                            cnt_q <= '0;
                            ptr_q <= '0;
                        end
                    end
                    ST_RECV: begin
                        if (rx_wr) cnt_q <= cnt_q + 1'b1;
                        if (rx_end) begin
                            ptr_q <= '0;
                            if (cnt_q != '0 || rx_wr) st_q <= ST_HOLD;
                            else                      st_q <= ST_IDLE;
                        end
                    end
                    ST_HOLD: begin
                        if (out_token) out_nak_q <= 1'b1;
                        if (port_rd) begin
                            if (adv >= {1'b0, cnt_q}) begin
                                st_q  <= ST_IDLE;
                                cnt_q <= '0;
                                ptr_q <= '0;
                            end else begin
                                ptr_q <= adv[CNT_W-1:0];
                            end
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/epb_endpoint_buffer.sv
// Module epb_endpoint_buffer
// Single-endpoint packet buffer between a processor data port and a USB
// SIE, working in either direction. It ties the length register, the byte
// storage and the sequencer together, and forms the read and transmit data.
// Assumes: synchronous active-low reset; dir_in is static while data is held.
module epb_endpoint_buffer
    import epb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MPS_W = 11,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              dir_in,
    input  logic              mps_wr,
    input  logic [MPS_W-1:0]  mps_data,
    input  logic              len_wr,
    input  logic [MPS_W-1:0]  len_data,
    input  logic              force_valid,
    input  logic              force_clear,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic              port_wide,
    input  logic [PORT_W-1:0] port_wdata,
    output logic [PORT_W-1:0] port_rdata,
    input  logic              in_token,
    output logic              in_nak,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_end,
    input  logic              out_token,
    output logic              out_nak,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    output logic              buf_ready,
    output logic [CNT_W-1:0]  buf_count,
    output logic [CNT_W-1:0]  pkt_len
);
    logic              wr_lo, wr_hi, rx_wr;
    logic [ADDR_W-1:0] wa0, wa1, ra0, ra1;
    logic [7:0]        rd0, rd1, wd0;
    logic              hold, hi_ok;

    epb_len_reg #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_reset(bus_reset),
        .mps_wr   (mps_wr),
        .mps_data (mps_data),
        .len_wr   (len_wr),
        .len_data (len_data),
        .len_q    (pkt_len)
    );

    epb_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .dir_in     (dir_in),
        .len_q      (pkt_len),
        .force_valid(force_valid),
        .force_clear(force_clear),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .port_wide  (port_wide),
        .in_token   (in_token),
        .out_token  (out_token),
        .rx_valid   (rx_valid),
        .rx_end     (rx_end),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .rx_wr      (rx_wr),
        .wa0        (wa0),
        .wa1        (wa1),
        .ra0        (ra0),
        .ra1        (ra1),
        .hold       (hold),
        .hi_ok      (hi_ok),
        .tx_valid   (tx_valid),
        .tx_end     (tx_end),
        .in_nak     (in_nak),
        .out_nak    (out_nak),
        .buf_ready  (buf_ready),
        .buf_count  (buf_count)
    );

    // Select the byte source for the low write port by direction.
    always_comb wd0 = dir_in ? port_wdata[7:0] : rx_data;

    epb_byte_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk),
        .we0(wr_lo || rx_wr),
        .wa0(wa0),
        .wd0(wd0),
        .we1(wr_hi),
        .wa1(wa1),
        .wd1(port_wdata[15:8]),
        .ra0(ra0),
        .rd0(rd0),
        .ra1(ra1),
        .rd1(rd1)
    );

    // Form the processor read word and the transmit byte.
    always_comb begin
        port_rdata = hold ? {(hi_ok ? rd1 : 8'h00), rd0} : '0;
        tx_data    = tx_valid ? rd0 : '0;
    end
endmodule

// File: rtl/epb_endpoint_buffer_chk.sv
// Module epb_endpoint_buffer_chk
// Property checker for the endpoint buffer, attached by bind.
// Assumes: the same parameters as the bound instance.
module epb_endpoint_buffer_chk #(
    parameter int DEPTH = 64,
    parameter int MPS_W = 11,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             dir_in,
    input logic             mps_wr,
    input logic [MPS_W-1:0] mps_data,
    input logic             force_clear,
    input logic             port_wide,
    input logic [15:0]      port_rdata,
    input logic             in_token,
    input logic             in_nak,
    input logic             tx_valid,
    input logic             tx_end,
    input logic             out_token,
    input logic             out_nak,
    input logic             buf_ready,
    input logic [CNT_W-1:0] buf_count,
    input logic [CNT_W-1:0] pkt_len
);
    logic [CNT_W-1:0] mps_clamped;
    always_comb mps_clamped = (32'(mps_data) > DEPTH) ? CNT_W'(DEPTH) : mps_data[CNT_W-1:0];

    p_len_load_r1: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        mps_wr |=> pkt_len == $past(mps_clamped));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        32'(buf_count) <= DEPTH);

    p_nak_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        in_nak |-> $past(in_token) && !$past(buf_ready));

    p_tx_ready_r6: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        tx_valid |-> buf_ready);

    p_tx_end_frees_r6: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        (tx_end && !force_clear) |=> !buf_ready && buf_count == '0);

    p_out_nak_held_r8: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        out_nak |-> $past(out_token) && $past(buf_ready) && !dir_in);

    p_nak_single_r8: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        $onehot0({in_nak, out_nak}));

    p_wide_tail_r10: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        (!dir_in && buf_ready && port_wide && buf_count == CNT_W'(1)) |-> port_rdata[15:8] == 8'h00);

    p_rdata_empty_r11: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        !buf_ready |-> port_rdata == 16'h0000);

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        force_clear |=> !buf_ready && buf_count == '0);
endmodule

bind epb_endpoint_buffer epb_endpoint_buffer_chk #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .dir_in     (dir_in),
    .mps_wr     (mps_wr),
    .mps_data   (mps_data),
    .force_clear(force_clear),
    .port_wide  (port_wide),
    .port_rdata (port_rdata),
    .in_token   (in_token),
    .in_nak     (in_nak),
    .tx_valid   (tx_valid),
    .tx_end     (tx_end),
    .out_token  (out_token),
    .out_nak    (out_nak),
    .buf_ready  (buf_ready),
    .buf_count  (buf_count),
    .pkt_len    (pkt_len)
);

// File: tb/epb_endpoint_buffer_bench.sv
// Bench epb_endpoint_buffer_bench
// Drives the endpoint buffer through both directions and compares every
// output, every cycle, against a behavioural model built on a byte queue.
module epb_endpoint_buffer_bench;
    localparam int CLK_P  = 10;
    localparam int DEPTH  = 64;
    localparam int MPS_W  = 11;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int MAX_CYC = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, dir_in = 1'b1;
    logic mps_wr = 1'b0, len_wr = 1'b0;
    logic [MPS_W-1:0] mps_data = '0, len_data = '0;
    logic force_valid = 1'b0, force_clear = 1'b0;
    logic port_wr = 1'b0, port_rd = 1'b0, port_wide = 1'b0;
    logic [15:0] port_wdata = '0;
    logic [15:0] port_rdata;
    logic in_token = 1'b0, out_token = 1'b0;
    logic in_nak, tx_valid, tx_end, out_nak, buf_ready;
    logic [7:0] tx_data;
    logic rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = '0;
    logic [CNT_W-1:0] buf_count, pkt_len;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    epb_endpoint_buffer #(.DEPTH(DEPTH), .MPS_W(MPS_W)) u_epb_endpoint_buffer (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .dir_in(dir_in),
        .mps_wr(mps_wr), .mps_data(mps_data), .len_wr(len_wr), .len_data(len_data),
        .force_valid(force_valid), .force_clear(force_clear),
        .port_wr(port_wr), .port_rd(port_rd), .port_wide(port_wide),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .in_token(in_token), .in_nak(in_nak), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_end(tx_end),
        .out_token(out_token), .out_nak(out_nak),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .buf_ready(buf_ready), .buf_count(buf_count), .pkt_len(pkt_len)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;            // 0 idle, 1 send, 2 recv, 3 hold
    logic [7:0] q[$];
    int m_ptr = 0, m_len = 0, old_len = 0, cap = 0;
    bit m_valid = 0, m_innak = 0, m_outnak = 0;

    function automatic int clampv(input int v);
        return (v > DEPTH) ? DEPTH : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            q.delete(); m_ptr = 0; m_valid = 0; m_innak = 0; m_outnak = 0;
            m_len = 0; m_st = 0;
        end else begin
            old_len = m_len;
            m_innak = 0; m_outnak = 0;
            if (mps_wr) m_len = clampv(int'(mps_data));
            else if (len_wr) m_len = clampv(int'(len_data));
            if (force_clear) begin
                q.delete(); m_ptr = 0; m_valid = 0; m_st = 0;
            end else if (dir_in) begin
                if (m_st == 0) begin
                    if (in_token) begin
                        if (m_valid) begin m_st = 1; m_ptr = 0; end
                        else m_innak = 1;
                    end
                    if (!m_valid) begin
                        cap = (old_len != 0) ? old_len : DEPTH;
                        if (port_wr) begin
                            if (q.size() < cap) q.push_back(port_wdata[7:0]);
                            if (port_wide && q.size() < cap) q.push_back(port_wdata[15:8]);
                            if (old_len != 0 && q.size() >= old_len) m_valid = 1;
                        end
                        if (force_valid) m_valid = 1;
                    end
                end else if (m_st == 1) begin
                    if (m_ptr < q.size()) m_ptr++;
                    else begin q.delete(); m_ptr = 0; m_valid = 0; m_st = 0; end
                end
            end else begin
                if (m_st == 0) begin
                    if (out_token) begin m_st = 2; q.delete(); m_ptr = 0; end
                end else if (m_st == 2) begin
                    if (rx_valid && q.size() < DEPTH) q.push_back(rx_data);
                    if (rx_end) begin m_st = (q.size() > 0) ? 3 : 0; m_ptr = 0; end
                end else if (m_st == 3) begin
                    if (out_token) m_outnak = 1;
                    if (port_rd) begin
                        m_ptr += port_wide ? 2 : 1;
                        if (m_ptr >= q.size()) begin q.delete(); m_ptr = 0; m_st = 0; end
                    end
                end
            end
        end
    end

    // Compare every output against the model, a quarter period after the falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            int e_rd, e_tx;
            bit e_txv, e_txe, e_hold;
            e_hold = !dir_in && m_st == 3;
            e_txv  = dir_in && m_st == 1 && m_ptr < q.size();
            e_txe  = dir_in && m_st == 1 && m_ptr == q.size();
            e_tx   = e_txv ? int'(q[m_ptr]) : 0;
            e_rd   = 0;
            if (e_hold) begin
                e_rd = int'(q[m_ptr]);
                if (port_wide && m_ptr + 1 < q.size()) e_rd += int'(q[m_ptr+1]) << 8;
            end
            chk("R1 pkt_len", int'(pkt_len), m_len);
            chk("R3 buf_ready", int'(buf_ready), dir_in ? int'(m_valid) : int'(e_hold));
            chk("R3 buf_count", int'(buf_count), dir_in ? q.size() : q.size() - m_ptr);
            chk("R5 in_nak", int'(in_nak), int'(m_innak));
            chk("R8 out_nak", int'(out_nak), int'(m_outnak));
            chk("R6 tx_valid", int'(tx_valid), int'(e_txv));
            chk("R6 tx_end", int'(tx_end), int'(e_txe));
            chk("R6 tx_data", int'(tx_data), e_tx);
            chk("R9 port_rdata", int'(port_rdata), e_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clr();
        bus_reset = 0; mps_wr = 0; len_wr = 0; force_valid = 0; force_clear = 0;
        port_wr = 0; port_rd = 0; port_wide = 0; in_token = 0; out_token = 0;
        rx_valid = 0; rx_end = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); clr(); end
    endtask

    task automatic pwrite(input bit wide, input logic [15:0] d);
        @(negedge clk); clr(); port_wr = 1; port_wide = wide; port_wdata = d;
    endtask

    task automatic pread(input bit wide);
        @(negedge clk); clr(); port_rd = 1; port_wide = wide;
    endtask

    task automatic rxbyte(input logic [7:0] d);
        @(negedge clk); clr(); rx_valid = 1; rx_data = d;
    endtask

    // Drive port_wide without reading and sample port_rdata.
    task automatic peek(input bit wide, input int exp, input string tag);
        @(negedge clk); clr(); port_wide = wide;
        #(CLK_P/4);
        chk(tag, int'(port_rdata), exp);
    endtask

    // Check a value after the inputs have been quiet for one cycle.
    task automatic settle_chk(input string tag, input int act_sel, input int exp);
        int a;
        idle(1);
        #(CLK_P/4);
        a = (act_sel == 0) ? int'(buf_ready) : (act_sel == 1) ? int'(buf_count) : int'(pkt_len);
        chk(tag, a, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle_chk("R2 reset buf_ready", 0, 0);
        settle_chk("R2 reset pkt_len", 2, 0);

        // IN: size write loads length
        @(negedge clk); clr(); mps_wr = 1; mps_data = 8;
        settle_chk("R1 size loads length", 2, 8);

        // IN token before commit -> NAK
        @(negedge clk); clr(); in_token = 1;
        @(negedge clk); clr(); #(CLK_P/4); chk("R5 nak pulse", int'(in_nak), 1);

        // fill with 16-bit writes, auto-commit at 8
        pwrite(1, 16'h0201); pwrite(1, 16'h0403); pwrite(1, 16'h0605);
        settle_chk("R3 not yet ready", 0, 0);
        pwrite(1, 16'h0807);
        settle_chk("R3 auto commit", 0, 1);
        pwrite(1, 16'hAAAA);
        settle_chk("R6 write ignored while ready", 1, 8);
        @(negedge clk); clr(); in_token = 1;
        idle(12);
        settle_chk("R6 freed after send", 1, 0);

        // short packet via smaller length; 16-bit write trimmed at length
        @(negedge clk); clr(); len_wr = 1; len_data = 3;
        pwrite(1, 16'h1211); pwrite(1, 16'h1413);
        settle_chk("R3 trimmed count", 1, 3);
        settle_chk("R3 short commit", 0, 1);
        @(negedge clk); clr(); in_token = 1;
        idle(6);

        // force-validate after one byte, then a zero-length packet
        pwrite(0, 16'h0055);
        @(negedge clk); clr(); force_valid = 1;
        settle_chk("R4 forced commit", 0, 1);
        @(negedge clk); clr(); in_token = 1;
        idle(4);
        @(negedge clk); clr(); force_valid = 1;
        settle_chk("R4 zero length commit", 0, 1);
        @(negedge clk); clr(); in_token = 1;
        idle(3);
        settle_chk("R6 zero length sent", 0, 0);

        // size and length together, clamped
        @(negedge clk); clr(); mps_wr = 1; mps_data = 100; len_wr = 1; len_data = 5;
        settle_chk("R1 priority and clamp", 2, 64);

        // bus reset clears the length
        @(negedge clk); clr(); bus_reset = 1;
        settle_chk("R2 bus reset length", 2, 0);

        // zero length: no auto commit; force-clear empties
        pwrite(0, 16'h0077);
        settle_chk("R3 no auto commit at zero length", 0, 0);
        @(negedge clk); clr(); force_clear = 1;
        settle_chk("R12 clear in IN", 1, 0);

        // OUT direction
        @(negedge clk); clr(); dir_in = 0;
        @(negedge clk); clr(); out_token = 1;
        rxbyte(8'h31); rxbyte(8'h32); rxbyte(8'h33); rxbyte(8'h34);
        @(negedge clk); clr(); rx_end = 1;
        settle_chk("R7 packet held", 1, 4);
        @(negedge clk); clr(); out_token = 1;
        @(negedge clk); clr(); #(CLK_P/4); chk("R8 out nak", int'(out_nak), 1);
        settle_chk("R8 contents kept", 1, 4);
        peek(0, 16'h0031, "R9 narrow view");
        pread(0);
        peek(1, 16'h3332, "R9 wide view");
        pread(1);
        peek(1, 16'h0034, "R10 wide tail");
        pread(1);
        settle_chk("R10 tail emptied", 0, 0);
        peek(1, 16'h0000, "R11 empty reads zero");

        // new packet accepted, then force-cleared
        @(negedge clk); clr(); out_token = 1;
        rxbyte(8'h41); rxbyte(8'h42);
        @(negedge clk); clr(); rx_end = 1;
        settle_chk("R11 new packet accepted", 1, 2);
        @(negedge clk); clr(); force_clear = 1;
        settle_chk("R12 clear in OUT", 1, 0);

        // zero-byte OUT packet leaves the buffer empty
        @(negedge clk); clr(); out_token = 1;
        @(negedge clk); clr(); rx_end = 1;
        settle_chk("R7 empty packet", 0, 0);

        idle(3);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected less than %0d cycles", MAX_CYC, MAX_CYC);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule